// File: doc/BRIEF.md
# Content-Directed Pointer Prefetcher

This block watches cache fills as they come back from memory and looks for values inside the returned block that appear to be pointers. It treats each 32-bit word of the 64-byte block as a possible address. A word counts as a pointer when its top twelve bits equal the top twelve bits of the fill's own address, which means it points into the same 1 MB region. It keeps no table of past addresses, so it can chase pointers that have never been referenced before.

A fill is taken in one cycle, and all sixteen words are compared in parallel during that cycle. The surviving targets are held as a pending set. They leave one per handshake on a valid/ready request port, lowest word index first, each rounded down to its 64-byte line. The fill port stays closed until the pending set has been fully drained. Two kinds of target are dropped within a block: a target that lands on the fill's own line, and a second target that lands on a line already requested.

Top module: `cdp_prefetcher`

## Requirements
- R1: Word i of a fill occupies `fill_data[32*i+31 : 32*i]`. A word is a candidate only when its bits 31:20 equal bits 31:20 of `fill_addr`. A word differing in any of those bits (for example only bit 20 or only bit 31) produces no request.
- R2: Every candidate that is not removed by R4 or R5 produces exactly one request, whatever its bits 19:0 are.
- R3: Each request address is the candidate word with bits 5:0 forced to zero.
- R4: A candidate whose bits 31:6 equal bits 31:6 of `fill_addr` produces no request.
- R5: Within one fill, when several candidates share bits 31:6, only the one with the lowest word index produces a request.
- R6: Requests leave in ascending word-index order, at most one per cycle, and one is consumed on each cycle where `pf_valid` and `pf_ready` are both high.
- R7: `fill_ready` is low while any request from the current fill is still pending. A fill offered during that time is not taken and produces no requests.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` keeps its value into the next cycle.
- R9: After reset, `pf_valid` is low and `fill_ready` is high, and anything pending before reset is discarded. Reset asserts asynchronously and is released two clock edges after `rst_n` rises.
- R10: Nothing is remembered across fills. A fill with no candidates produces no requests, and repeating an identical fill produces the same requests again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fill_valid | input | 1 | A fill is offered |
| fill_ready | output | 1 | The block can take a fill |
| fill_addr | input | 32 | Address of the filled block |
| fill_data | input | 512 | Sixteen 32-bit words of the fill, word 0 in the low bits |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the request |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
The embedded properties check the following on every cycle:
- every request is line aligned, stays in the fill's region and never names the fill's own line;
- a stalled request holds its value;
- the fill port stays closed while a stalled request is waiting;
- each pop removes exactly the lowest pending word;
- a fresh fill loads exactly as many pending words as the comparators flagged.

Some behaviour can only be shown by the bench's scenarios. These include the exact set and order of addresses for fills mixing foreign words, same-line words and repeated lines, and the refusal of a fill offered while busy. They also include the discarding of pending work at reset and the repeat of an identical fill.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int ADDR_W   = 32;
  localparam int WORD_CNT = 16;
  localparam int OFS_W    = 6;   // log2 of the 64-byte line
  localparam int TAG_LO   = 20;  // lowest bit of the region compare
  localparam int LINE_W   = ADDR_W - OFS_W;
  localparam int IDX_W    = $clog2(WORD_CNT);
  localparam int DATA_W   = ADDR_W * WORD_CNT;
endpackage

// File: rtl/cdp_rst_sync.sv
module cdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/cdp_match.sv
module cdp_match #(
  parameter int AW  = 32,
  parameter int NW  = 16,
  parameter int OW  = 6,
  parameter int TL  = 20,
  localparam int LW = AW - OW
) (
  input  logic [AW-1:0]    blk_addr,
  input  logic [AW*NW-1:0] blk_data,
  output logic [NW-1:0]    keep_mask,
  output logic [LW*NW-1:0] line_flat
);
  logic [LW-1:0] line_w [NW];
  logic [NW-1:0] cand;

  // Region compare and own-line suppression for every word in parallel.
  always_comb begin
    for (int i = 0; i < NW; i++) begin
      line_w[i] = blk_data[i*AW+OW +: LW];
      cand[i]   = (blk_data[i*AW+TL +: AW-TL] == blk_addr[AW-1:TL]) &&
                  (blk_data[i*AW+OW +: LW]    != blk_addr[AW-1:OW]);
      line_flat[i*LW +: LW] = line_w[i];
    end
  end

  // A candidate survives only if no lower-index candidate targets its line.
  for (genvar gi = 0; gi < NW; gi++) begin : g_dedup
    logic seen;
    always_comb begin
      seen = 1'b0;
      for (int j = 0; j < gi; j++) begin
        if (cand[j] && (line_w[j] == line_w[gi])) seen = 1'b1;
      end
      keep_mask[gi] = cand[gi] && !seen;
    end
  end
endmodule

// File: rtl/cdp_pick.sv
module cdp_pick #(
  parameter int NW  = 16,
  localparam int IW = $clog2(NW)
) (
  input  logic [NW-1:0] req,
  output logic [IW-1:0] idx,
  output logic [NW-1:0] grant,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any   = |req;
    grant = '0;
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/cdp_prefetcher.sv
module cdp_prefetcher #(
  parameter int ADDR_W   = cdp_pkg::ADDR_W,
  parameter int WORD_CNT = cdp_pkg::WORD_CNT,
  parameter int OFS_W    = cdp_pkg::OFS_W,
  parameter int TAG_LO   = cdp_pkg::TAG_LO,
  localparam int LINE_W  = ADDR_W - OFS_W,
  localparam int IDX_W   = $clog2(WORD_CNT),
  localparam int DATA_W  = ADDR_W * WORD_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  logic                       rst_s_n;
  logic [WORD_CNT-1:0]        hit_mask;
  logic [LINE_W*WORD_CNT-1:0] hit_lines;
  logic [WORD_CNT-1:0]        pend_q, pend_d;
  logic [LINE_W-1:0]          line_q [WORD_CNT];
  logic [LINE_W-1:0]          blk_line_q;
  logic [IDX_W-1:0]           pick_idx;
  logic [WORD_CNT-1:0]        pick_grant;
  logic                       pick_any;
  logic                       accept, pop;

  cdp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  cdp_match #(.AW(ADDR_W), .NW(WORD_CNT), .OW(OFS_W), .TL(TAG_LO)) u_match (
    .blk_addr  (fill_addr),
    .blk_data  (fill_data),
    .keep_mask (hit_mask),
    .line_flat (hit_lines)
  );

  cdp_pick #(.NW(WORD_CNT)) u_pick (
    .req   (pend_q),
    .idx   (pick_idx),
    .grant (pick_grant),
    .any   (pick_any)
  );

  assign fill_ready = rst_s_n && (pend_q == '0);
  assign accept     = fill_valid && fill_ready;
  assign pf_valid   = pick_any;
  assign pop        = pf_valid && pf_ready;
  assign pf_addr    = {line_q[pick_idx], {OFS_W{1'b0}}};

  // Next state of the pending set.
  always_comb begin
    pend_d = pend_q;
    if (accept)   pend_d = hit_mask;
    else if (pop) pend_d = pend_q & ~pick_grant;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  // Target lines and fill line load only when a fill is taken.
  for (genvar gw = 0; gw < WORD_CNT; gw++) begin : g_line
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)    line_q[gw] <= '0;
      else if (accept) line_q[gw] <= hit_lines[gw*LINE_W +: LINE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    blk_line_q <= '0;
    else if (accept) blk_line_q <= fill_addr[ADDR_W-1:OFS_W];
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_s_n)
    pf_valid |-> (pf_addr[OFS_W-1:0] == '0)); // R3
  AST_SAME_REGION: assert property (@(posedge clk) disable iff (!rst_s_n)
    pf_valid |-> (pf_addr[ADDR_W-1:TAG_LO] == blk_line_q[LINE_W-1:TAG_LO-OFS_W])); // R1
  AST_NOT_OWN_LINE: assert property (@(posedge clk) disable iff (!rst_s_n)
    pf_valid |-> (pf_addr[ADDR_W-1:OFS_W] != blk_line_q)); // R4
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pf_valid && !pf_ready) |=> pf_valid); // R8
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pf_valid && !pf_ready) |=> $stable(pf_addr)); // R8
  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pf_valid && !pf_ready) |=> !fill_ready); // R7
  AST_POP_LOWEST: assert property (@(posedge clk) disable iff (!rst_s_n)
    pop |=> ((pend_q & ~({WORD_CNT{1'b1}} << ($past(pick_idx) + 1))) == '0)); // R6
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    pop |=> ($countones(pend_q) == $past($countones(pend_q)) - 1)); // R6
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> ($countones(pend_q) == $past($countones(hit_mask)))); // R2
endmodule

// File: tb/sim_cdp_prefetcher.sv
module sim_cdp_prefetcher;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] hit;
    logic [15:0] dup;
    logic [15:0] own;
    logic [7:0]  exp_n;
  } vec_t;

  // addr, pointer words, repeated-line words, own-line words, expected count
  localparam vec_t VECS [8] = '{
    '{32'h80011100, 16'h0004, 16'h0000, 16'h0000, 8'd1},
    '{32'h12345680, 16'hFFFF, 16'h0000, 16'h0000, 8'd16},
    '{32'h00000040, 16'h0000, 16'h0000, 16'hFFFF, 8'd0},
    '{32'hFFF00000, 16'h8001, 16'h0000, 16'h0000, 8'd2},
    '{32'hABCDEFC0, 16'h0F0F, 16'h0A0A, 16'h0000, 8'd4},
    '{32'h7FF00000, 16'h00F0, 16'h0000, 16'h0100, 8'd4},
    '{32'h00000000, 16'h0000, 16'h0000, 16'h0000, 8'd0},
    '{32'h5A5A5A40, 16'hAAAA, 16'h0000, 16'h0001, 8'd8}
  };

  logic         clk, rst_n;
  logic         fill_valid, fill_ready;
  logic [31:0]  fill_addr;
  logic [511:0] fill_data;
  logic         pf_valid, pf_ready;
  logic [31:0]  pf_addr;

  int total = 0;
  int bad = 0;
  int wd = 0;
  logic [31:0] got_q [32];
  int          got_n;
  logic [31:0] exp_q [16];
  int          exp_n;

  cdp_prefetcher u0 (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_data(fill_data),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL watchdog R6 act=%0d exp=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] a, input int i);
    logic [13:0] l;
    l = a[19:6] + 14'h100 + 14'(i);
    return {a[31:20], l, 6'h00};
  endfunction

  // Build fill data and the expected request list for one vector.
  task automatic build(input vec_t v);
    exp_n = 0;
    for (int i = 0; i < NW; i++) begin
      logic [31:0] w;
      if (v.own[i])      w = {v.addr[31:6], 6'(i)};
      else if (v.dup[i]) w = tgt(v.addr, i - 1) | 32'h3F;
      else if (v.hit[i]) w = tgt(v.addr, i) | 32'(i * 3 + 1) % 64;
      else if (i % 2)    w = {v.addr[31:20] ^ 12'h800, 20'(i * 32'h1111)};
      else               w = {v.addr[31:20] ^ 12'h001, 20'(i * 32'h1111)};
      fill_data[32*i +: 32] = w;
      if (v.hit[i] && !v.dup[i] && !v.own[i]) begin
        exp_q[exp_n] = tgt(v.addr, i);
        exp_n++;
      end
    end
    fill_addr = v.addr;
  endtask

  task automatic send();
    @(negedge clk);
    fill_valid = 1'b1;
    while (!fill_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic drain(input int mode);
    int idle = 0;
    int cyc = 0;
    logic stalled = 1'b0;
    logic [31:0] held = '0;
    got_n = 0;
    while (idle < 6 && cyc < 600) begin
      @(negedge clk);
      if (stalled) chk(pf_valid && pf_addr == held, "R8", pf_addr, held);
      pf_ready = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) != 0);
      if (pf_valid) begin
        idle = 0;
        if (pf_ready) begin
          if (got_n < 32) got_q[got_n] = pf_addr;
          got_n++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          held = pf_addr;
        end
      end else begin
        idle++;
        stalled = 1'b0;
      end
      cyc++;
    end
    pf_ready = 1'b0;
  endtask

  task automatic compare(input int n_req, input string tag);
    chk(got_n == n_req, tag, 32'(got_n), 32'(n_req));
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_q[k] == exp_q[k], tag, got_q[k], exp_q[k]);
  endtask

  initial begin
    rst_n = 1'b1; fill_valid = 1'b0; pf_ready = 1'b0;
    fill_addr = '0; fill_data = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pf_valid, "R9", 32'(pf_valid), 32'h0);
    chk(fill_ready, "R9", 32'(fill_ready), 32'h1);

    // Table walk: R1 R2 R3 R4 R5 R6 R8 R10, with varied backpressure.
    for (int e = 0; e < 8; e++) begin
      build(VECS[e]);
      send();
      drain(e % 4);
      compare(int'(VECS[e].exp_n), "R2/R1/R4/R5/R6");
    end

    // R10: identical fill repeated yields the same requests again.
    build(VECS[0]);
    send(); drain(0);
    compare(int'(VECS[0].exp_n), "R10");

    // R7: a fill offered while busy is refused and adds nothing.
    build(VECS[1]);
    send();
    @(negedge clk);
    fill_addr = VECS[4].addr;
    fill_data = ~fill_data;
    fill_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!fill_ready, "R7", 32'(fill_ready), 32'h0);
    end
    fill_valid = 1'b0;
    build(VECS[1]);
    drain(0);
    compare(16, "R7");
    chk(fill_ready, "R7", 32'(fill_ready), 32'h1);

    // R9: reset discards pending requests.
    build(VECS[7]);
    send();
    chk(pf_valid, "R9", 32'(pf_valid), 32'h1);
    rst_n = 1'b0;
    #1;
    chk(!pf_valid, "R9", 32'(pf_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pf_valid && fill_ready, "R9", {30'h0, pf_valid, fill_ready}, 32'h1);
    drain(0);
    chk(got_n == 0, "R9", 32'(got_n), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule